// File: doc/BRIEF.md
# Reservation Monitor for Atomic Word Access

This block stands between one processor thread and a small word-organised data memory, which it contains. It turns a stream of requests into memory accesses and one response per request. Besides plain loads and stores it provides the three primitives that lock and semaphore code is built from. The first is a reserving load, which reads a word and remembers its address. The second is a conditional store, which writes only when nothing has written that word since the reserving load. The third is a swap, which exchanges a register value with a memory word in one step.

Only one reservation is held, as a valid flag and a word index. Every write that reaches memory is compared against it. This covers the thread's own stores, its swaps and its successful conditional stores. It also covers writes from other agents, which come in on a separate write port and always take precedence over the thread. A conditional store reports its outcome as a value for the destination register, 0 when it committed and 1 when it did not, so software can loop until it succeeds. Addresses are byte addresses taken straight from a register, with no offset added. They must be word-aligned.

Top module: `lrsc_monitor`

## Requirements
- R1: Request codes on `req_op` are 0 load, 1 store, 2 reserving load, 3 conditional store and 4 swap. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and exactly one response (`rsp_valid` high for one cycle) appears in the following cycle. A load returns the word at `req_addr`. A store writes `req_wdata` and returns 0.
- R2: A reserving load returns the word at its address and records a reservation on that word.
- R3: A conditional store to the reserved word, with the reservation still valid, writes its data and returns 0.
- R4: A conditional store with no valid reservation, or to a word other than the reserved one, leaves memory unchanged and returns 1.
- R5: Every conditional store drops the reservation, whether it commits or fails, so a second one to the same word fails.
- R6: A store or swap from the thread to the reserved word drops the reservation. A store to another word keeps it, and so does a load.
- R7: A write on the agent port (`snoop_valid`, word index `snoop_addr`, data `snoop_wdata`) updates memory. It drops the reservation when it hits the reserved word and keeps it otherwise.
- R8: A new reserving load replaces the earlier reservation, so only the newest address can be stored to conditionally.
- R9: A swap returns the word held before it and leaves the new word in memory, with no other write able to fall between the read and the write.
- R10: While `snoop_valid` is high, `req_ready` is low. A request waiting during an agent write is accepted afterwards and sees that write.
- R11: A request with `req_addr[1:0]` not zero, or with an op code of 5 to 7, gets `rsp_err` high and a data value of 0. It changes neither memory nor the reservation.
- R12: Reset clears the reservation and any pending response, so a conditional store issued right after reset fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock internally |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Request code, see R1 |
| req_addr | input | AW (8) | Byte address, word-aligned |
| req_wdata | input | DW (32) | Store, conditional store or swap data |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DW (32) | Read word, or 0/1 outcome of a conditional store |
| rsp_err | output | 1 | Request was rejected (R11) |
| snoop_valid | input | 1 | Write from another agent |
| snoop_addr | input | AW-2 (6) | Word index of that write |
| snoop_wdata | input | DW (32) | Data of that write |

## Verification
The conditional store is exercised in several situations: after a clean reservation, after another conditional store, after a write by the thread or by the agent to the same word, after a write to a neighbouring word, after a second reserving load, and after reset. Memory is read back after each case, and the read value separates a commit from a refused write. Misaligned and undefined requests are placed between a reservation and its conditional store, which shows that they leave the reservation in place. A request offered in the same cycle as an agent write checks the precedence between the two, and it reads the word the agent wrote.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_LRSV  = 3'd2,
    OP_SCND  = 3'd3,
    OP_SWAP  = 3'd4
  } op_e;

  // response source selected for the cycle after acceptance
  typedef enum logic [1:0] {
    RK_ZERO = 2'd0,
    RK_READ = 2'd1,
    RK_FAIL = 2'd2,
    RK_ERR  = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic rd;        // request reads the memory word
    logic wr_always; // store or swap: writes unconditionally
    logic is_lrsv;
    logic is_scnd;
    logic bad;       // misaligned or undefined code
  } ctl_t;

  localparam int unsigned SC_FAIL_CODE = 1;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
  import lrsc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [2:0]    op,
  input  logic [AW-1:0] addr,
  output ctl_t          ctl
);

  logic misaligned;

  assign misaligned = |addr[1:0];

  always_comb begin
    ctl = '0;
    unique case (op)
      OP_LOAD:  ctl.rd = 1'b1;
      OP_STORE: ctl.wr_always = 1'b1;
      OP_LRSV: begin
        ctl.rd      = 1'b1;
        ctl.is_lrsv = 1'b1;
      end
      OP_SCND:  ctl.is_scnd = 1'b1;
      OP_SWAP: begin
        ctl.rd        = 1'b1;
        ctl.wr_always = 1'b1;
      end
      default:  ctl.bad = 1'b1;
    endcase
    if (misaligned) begin
      ctl = '0;
      ctl.bad = 1'b1;
    end
  end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int WAW = 6,
  parameter int NWP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic [WAW-1:0]           set_addr,
  input  logic                     sc_clr,
  input  logic [NWP-1:0]           wp_en,
  input  logic [NWP-1:0][WAW-1:0]  wp_addr,
  input  logic [WAW-1:0]           query_addr,
  output logic                     query_hit,
  output logic                     resv_valid_o,
  output logic [WAW-1:0]           resv_addr_o
);

  logic           valid_q, valid_d;
  logic [WAW-1:0] addr_q, addr_d;
  logic [NWP-1:0] wp_hit;
  logic           any_hit;

  for (genvar g = 0; g < NWP; g++) begin : g_wport
    assign wp_hit[g] = wp_en[g] && (wp_addr[g] == addr_q);
  end

  assign any_hit = |wp_hit;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    if (set_en) begin
      valid_d = 1'b1;
      addr_d  = set_addr;
    end else if (sc_clr || any_hit) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (set_en) addr_q <= addr_d;
    end
  end

  assign query_hit    = valid_q && (query_addr == addr_q);
  assign resv_valid_o = valid_q;
  assign resv_addr_o  = addr_q;

endmodule

// File: rtl/lrsc_wordmem.sv
module lrsc_wordmem #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int WAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [WAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [WAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  // read sees the word as it was before a same-cycle write
  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem_q[raddr];
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  input  logic          snoop_valid,
  input  logic [AW-3:0] snoop_addr,
  input  logic [DW-1:0] snoop_wdata
);

  localparam int WAW = AW - 2;
  localparam int NWP = 2;

  logic [1:0]  rst_sync_q;
  logic        rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  ctl_t           ctl;
  logic           acc;
  logic           ok;
  logic [WAW-1:0] widx;
  logic           sc_hit;
  logic           hart_we;
  logic           snoop_we;
  logic           mem_we;
  logic [WAW-1:0] mem_waddr;
  logic [DW-1:0]  mem_wdata;
  logic           mem_re;
  logic [DW-1:0]  mem_rdata;
  logic           resv_valid;
  logic [WAW-1:0] resv_addr;
  logic [NWP-1:0]          wp_en;
  logic [NWP-1:0][WAW-1:0] wp_addr;

  lrsc_decode #(.AW(AW)) u_dec (
    .op   (req_op),
    .addr (req_addr),
    .ctl  (ctl)
  );

  assign req_ready = rst_q_n && !snoop_valid;
  assign acc       = req_valid && req_ready;
  assign ok        = acc && !ctl.bad;
  assign widx      = req_addr[AW-1:2];
  assign snoop_we  = snoop_valid && rst_q_n;

  assign hart_we = ok && (ctl.wr_always || (ctl.is_scnd && sc_hit));
  assign mem_re  = ok && ctl.rd;

  // the agent port wins; acceptance already excludes overlap
  always_comb begin
    mem_we    = hart_we || snoop_we;
    mem_waddr = widx;
    mem_wdata = req_wdata;
    if (snoop_we) begin
      mem_waddr = snoop_addr;
      mem_wdata = snoop_wdata;
    end
  end

  assign wp_en   = {snoop_we, hart_we};
  assign wp_addr = {snoop_addr, widx};

  lrsc_resv #(.WAW(WAW), .NWP(NWP)) u_resv (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .set_en       (ok && ctl.is_lrsv),
    .set_addr     (widx),
    .sc_clr       (ok && ctl.is_scnd),
    .wp_en        (wp_en),
    .wp_addr      (wp_addr),
    .query_addr   (widx),
    .query_hit    (sc_hit),
    .resv_valid_o (resv_valid),
    .resv_addr_o  (resv_addr)
  );

  lrsc_wordmem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (widx),
    .rdata (mem_rdata)
  );

  rsp_kind_e kind_d, kind_q;
  logic      rvalid_q;

  always_comb begin
    kind_d = RK_ZERO;
    if (ctl.bad)                   kind_d = RK_ERR;
    else if (ctl.rd)               kind_d = RK_READ;
    else if (ctl.is_scnd && !sc_hit) kind_d = RK_FAIL;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rvalid_q <= 1'b0;
      kind_q   <= RK_ZERO;
    end else begin
      rvalid_q <= acc;
      if (acc) kind_q <= kind_d;
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_err   = rvalid_q && (kind_q == RK_ERR);

  always_comb begin
    rsp_data = '0;
    if (rvalid_q) begin
      unique case (kind_q)
        RK_READ: rsp_data = mem_rdata;
        RK_FAIL: rsp_data = DW'(SC_FAIL_CODE);
        default: rsp_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          snoop_valid,
  input logic [AW-3:0] snoop_addr,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_err,
  input logic          resv_valid,
  input logic [AW-3:0] resv_addr,
  input logic          hart_we
);

  logic acc_c, aligned_c, sc_seen_q;

  assign acc_c     = req_valid && req_ready;
  assign aligned_c = (req_addr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) sc_seen_q <= 1'b0;
    else          sc_seen_q <= acc_c && aligned_c && (req_op == 3'd3);
  end

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    acc_c |=> rsp_valid);

  a_r1_no_extra_rsp: assert property (@(posedge clk) disable iff (!rst_q_n)
    !acc_c |=> !rsp_valid);

  a_r10_agent_first: assert property (@(posedge clk) disable iff (!rst_q_n)
    snoop_valid |-> !req_ready);

  a_r4_sc_code: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && sc_seen_q) |-> (!rsp_err && rsp_data <= DW'(1)));

  a_r4_sc_no_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_c && aligned_c && req_op == 3'd3 && !resv_valid) |-> !hart_we);

  a_r5_sc_drops: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_c && aligned_c && req_op == 3'd3) |=> !resv_valid);

  a_r7_agent_drops: assert property (@(posedge clk) disable iff (!rst_q_n)
    (snoop_valid && resv_valid && snoop_addr == resv_addr) |=> !resv_valid);

  a_r8_lr_sets: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_c && aligned_c && req_op == 3'd2)
      |=> (resv_valid && resv_addr == $past(req_addr[AW-1:2])));

  a_r11_bad_err: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_c && !aligned_c) |=> rsp_err);

  a_r11_bad_keeps: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_c && (!aligned_c || req_op > 3'd4))
      |=> (resv_valid == $past(resv_valid) && resv_addr == $past(resv_addr)));

endmodule

bind lrsc_monitor lrsc_monitor_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .snoop_valid (snoop_valid),
  .snoop_addr  (snoop_addr),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .rsp_err     (rsp_err),
  .resv_valid  (resv_valid),
  .resv_addr   (resv_addr),
  .hart_we     (hart_we)
);

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH) + 2;

  logic          clk, rst_n;
  logic          req_valid, req_ready;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_data;
  logic          snoop_valid;
  logic [AW-3:0] snoop_addr;
  logic [DW-1:0] snoop_wdata;

  lrsc_monitor #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  logic [DW-1:0] mm [DEPTH];
  logic          m_rv;
  logic [AW-3:0] m_ra;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit cond, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference behaviour taken from the requirements
  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
    exp_t e;
    logic [AW-3:0] w;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    w = a[AW-1:2];
    e.tag = tag; e.err = 1'b0; e.data = '0;
    if (a[1:0] != 2'b00 || op > 3'd4) begin
      e.err = 1'b1;
    end else begin
      case (op)
        3'd0: e.data = mm[w];
        3'd1: begin mm[w] = d; if (m_rv && m_ra == w) m_rv = 1'b0; end
        3'd2: begin e.data = mm[w]; m_rv = 1'b1; m_ra = w; end
        3'd3: begin
          if (m_rv && m_ra == w) mm[w] = d;
          else                   e.data = 1;
          m_rv = 1'b0;
        end
        default: begin
          e.data = mm[w]; mm[w] = d;
          if (m_rv && m_ra == w) m_rv = 1'b0;
        end
      endcase
    end
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic agent_write(input logic [AW-3:0] w, input logic [DW-1:0] d);
    snoop_valid = 1'b1; snoop_addr = w; snoop_wdata = d;
    mm[w] = d;
    if (m_rv && m_ra == w) m_rv = 1'b0;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected response", rsp_data, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_err == e.err, e.tag, DW'(rsp_err), DW'(e.err));
        if (!e.err) check(rsp_data == e.data, e.tag, rsp_data, e.data);
        else        check(rsp_data == '0, e.tag, rsp_data, '0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    snoop_valid = 1'b0; snoop_addr = '0; snoop_wdata = '0;
    m_rv = 1'b0; m_ra = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rsp_valid && req_ready, "R12 reset state", DW'(rsp_valid), '0);

    // R1: fill and read back
    for (int i = 0; i < 16; i++) issue(3'd1, AW'(i*4), 32'hA500_0000 + DW'(i*17), "R1 store");
    for (int i = 0; i < 16; i += 3) issue(3'd0, AW'(i*4), '0, "R1 load");

    // R2, R3, R5
    issue(3'd2, 8'h10, '0, "R2 reserving load");
    issue(3'd3, 8'h10, 32'h1111_0001, "R3 sc commits");
    issue(3'd0, 8'h10, '0, "R3 readback");
    issue(3'd3, 8'h10, 32'h2222_0002, "R5 second sc fails");
    issue(3'd0, 8'h10, '0, "R5 readback");

    // R4
    issue(3'd3, 8'h14, 32'h3333_0003, "R4 sc no reservation");
    issue(3'd2, 8'h18, '0, "R2 reserve");
    issue(3'd3, 8'h1C, 32'h4444_0004, "R4 sc other word");
    issue(3'd0, 8'h1C, '0, "R4 readback");
    issue(3'd3, 8'h18, 32'h5555_0005, "R5 dropped by failed sc");

    // R6
    issue(3'd2, 8'h20, '0, "R6 reserve");
    issue(3'd1, 8'h24, 32'h6666_0006, "R6 store other word");
    issue(3'd0, 8'h20, '0, "R6 load keeps");
    issue(3'd3, 8'h20, 32'h6666_0106, "R6 sc still commits");
    issue(3'd2, 8'h20, '0, "R6 reserve");
    issue(3'd1, 8'h20, 32'h6666_0206, "R6 store same word");
    issue(3'd3, 8'h20, 32'h6666_0306, "R6 sc after store fails");
    issue(3'd2, 8'h20, '0, "R6 reserve");
    issue(3'd4, 8'h20, 32'h6666_0406, "R9 swap");
    issue(3'd3, 8'h20, 32'h6666_0506, "R6 sc after swap fails");

    // R7
    issue(3'd2, 8'h08, '0, "R7 reserve");
    agent_write(6'd3, 32'h7777_0007);
    issue(3'd3, 8'h08, 32'h7777_0107, "R7 other-word agent keeps");
    issue(3'd2, 8'h08, '0, "R7 reserve");
    agent_write(6'd2, 32'h7777_0207);
    issue(3'd0, 8'h08, '0, "R7 agent data in memory");
    issue(3'd3, 8'h08, 32'h7777_0307, "R7 agent hit drops");

    // R8
    issue(3'd2, 8'h00, '0, "R8 reserve a");
    issue(3'd2, 8'h04, '0, "R8 reserve b");
    issue(3'd3, 8'h00, 32'h8888_0008, "R8 old reservation gone");
    issue(3'd2, 8'h00, '0, "R8 reserve a");
    issue(3'd2, 8'h04, '0, "R8 reserve b");
    issue(3'd3, 8'h04, 32'h8888_0108, "R8 newest commits");

    // R9
    issue(3'd4, 8'h30, 32'h9999_0009, "R9 swap returns old");
    issue(3'd4, 8'h30, 32'h9999_0109, "R9 swap returns new");
    issue(3'd0, 8'h30, '0, "R9 readback");

    // R10: agent write and request in the same cycle
    drain();
    snoop_valid = 1'b1; snoop_addr = 6'd13; snoop_wdata = 32'hAAAA_000A;
    req_valid = 1'b1; req_op = 3'd0; req_addr = 8'h34; req_wdata = '0;
    #1;
    check(!req_ready, "R10 ready low during agent write", DW'(req_ready), '0);
    mm[13] = 32'hAAAA_000A;
    if (m_rv && m_ra == 6'd13) m_rv = 1'b0;
    @(negedge clk);
    snoop_valid = 1'b0;
    issue(3'd0, 8'h34, '0, "R10 load sees agent data");

    // R11
    issue(3'd2, 8'h20, '0, "R11 reserve");
    issue(3'd2, 8'h21, '0, "R11 misaligned reserve");
    issue(3'd3, 8'h22, 32'hBBBB_000B, "R11 misaligned sc");
    issue(3'd1, 8'h25, 32'hBBBB_010B, "R11 misaligned store");
    issue(3'd5, 8'h20, 32'hBBBB_020B, "R11 undefined op");
    issue(3'd7, 8'h24, 32'hBBBB_030B, "R11 undefined op");
    issue(3'd0, 8'h24, '0, "R11 memory untouched");
    issue(3'd3, 8'h20, 32'hBBBB_040B, "R11 reservation kept");

    // R12
    issue(3'd2, 8'h28, '0, "R12 reserve before reset");
    drain();
    rst_n = 1'b0;
    m_rv = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rsp_valid, "R12 no response after reset", DW'(rsp_valid), '0);
    issue(3'd3, 8'h28, 32'hCCCC_000C, "R12 sc after reset fails");
    issue(3'd0, 8'h28, '0, "R12 readback");

    drain();
    check(sb.size() == 0, "R1 all responses seen", DW'(sb.size()), '0);
    finish_run();
  end

endmodule